// File: doc/BRIEF.md
# Interval-Driven Instruction Window Resizer

This block sets how many 8-entry segments of an out-of-order instruction window are powered and in use. It divides time into fixed intervals of 256 clock cycles. Within each interval it counts a single-bit event pulse, which stands in for the performance lost to a smaller window (for example, issue hazards). At the last cycle of each interval it compares the count with a high and a low threshold. A high count adds one segment. A low count removes one segment. A count between the thresholds leaves the size as it is.

A frame-level power manager supplies an upper bound on the segment count, and the block never exceeds it. The size never falls below two segments. When the window grows, the newly enabled segment needs time to come up, so the block asserts a stall output for a fixed number of cycles. The window storage and the issue logic are not part of this block. They only consume the segment count and the stall.

Top module: `winrs_window_resizer`

## Requirements
- R1: The segment count changes only on the clock edge that ends an interval. The first interval ends on the 256th rising edge after reset is released, and every later interval ends 256 edges after the previous one.
- R2: The decision uses the number of cycles with `hazard_i` high during the interval, including its last cycle. The count restarts from zero after each interval ends, so no events carry into the next decision.
- R3: If the count is strictly greater than `thr_hi_i` and the size is below the effective cap, the size grows by exactly one segment.
- R4: If the count is strictly less than `thr_lo_i` and the size is above the minimum, the size shrinks by exactly one segment. A count equal to either threshold, or between them, leaves the size unchanged.
- R5: The active segment count is never below 2, and a shrink decision at 2 segments has no effect.
- R6: The effective cap is `cap_i` clamped to the range 2 to 16. The size never grows above the effective cap. If the size is above the effective cap when an interval ends, it is set to the effective cap in that one step, whatever the count is.
- R7: Every grow step raises `stall_o` in the same cycle the new count appears, and holds it for exactly 5 cycles. Hold, shrink and clamp decisions never raise `stall_o`.
- R8: After reset, `active_segs_o` is 16 and `stall_o` is low.
- R9: If the count satisfies both the grow and the shrink conditions (possible only when `thr_lo_i` exceeds `thr_hi_i`), the block grows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hazard_i | input | 1 | Loss-proxy event, counted once per cycle while high |
| cap_i | input | 5 | Upper bound on active segments from the frame-level controller |
| thr_hi_i | input | 9 | Grow threshold; the count must exceed it to grow |
| thr_lo_i | input | 9 | Shrink threshold; the count must be below it to shrink |
| active_segs_o | output | 5 | Number of active 8-entry window segments |
| stall_o | output | 1 | High while a newly enabled segment is coming up |

## Verification
The assertions assume the interval is longer than the grow delay, so a new grow never starts while a stall is still running. They also assume `hazard_i` is a clean one-bit level sampled once per cycle. The bench drives every input on falling edges and changes `cap_i` and the thresholds only between intervals. This keeps each decision based on settled values. The bench also keeps its interval loop in lockstep with reset release, so the boundary it expects matches the one the timer produces.

// File: rtl/winrs_pkg.sv
package winrs_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_GROW   = 2'd1,
    ACT_SHRINK = 2'd2,
    ACT_CLAMP  = 2'd3
  } resize_act_e;

endpackage

// File: rtl/winrs_interval_timer.sv
module winrs_interval_timer #(
  parameter int INTERVAL_CYCLES = 256,
  localparam int TW = (INTERVAL_CYCLES < 2) ? 1 : $clog2(INTERVAL_CYCLES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic boundary_o
);

  logic [TW-1:0] tick_q;

  assign boundary_o = (tick_q == TW'(INTERVAL_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tick_q <= '0;
    else if (boundary_o) tick_q <= '0;
    else                 tick_q <= tick_q + 1'b1;
  end

  // R1: boundaries are isolated single-cycle pulses
  a_r1_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_o |=> !boundary_o);

endmodule

// File: rtl/winrs_event_counter.sv
module winrs_event_counter #(
  parameter int CW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hazard_i,
  input  logic          boundary_i,
  output logic [CW-1:0] loss_cnt_o
);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   sum;

  // include the pulse of the current cycle so the last cycle of the interval counts
  assign sum        = {1'b0, cnt_q} + {{CW{1'b0}}, hazard_i};
  assign loss_cnt_o = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (boundary_i) cnt_q <= '0;
    else                 cnt_q <= loss_cnt_o;
  end

  // R2: nothing carries across a boundary
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i |=> (cnt_q == '0));

endmodule

// File: rtl/winrs_size_ctrl.sv
module winrs_size_ctrl
  import winrs_pkg::*;
#(
  parameter int NUM_SEGS = 16,
  parameter int MIN_SEGS = 2,
  parameter int CW       = 9,
  localparam int SEG_W   = $clog2(NUM_SEGS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boundary_i,
  input  logic [CW-1:0]    loss_cnt_i,
  input  logic [CW-1:0]    thr_hi_i,
  input  logic [CW-1:0]    thr_lo_i,
  input  logic [SEG_W-1:0] cap_i,
  output logic [SEG_W-1:0] size_o,
  output logic             grow_o
);

  localparam logic [SEG_W-1:0] MinV = SEG_W'(MIN_SEGS);
  localparam logic [SEG_W-1:0] MaxV = SEG_W'(NUM_SEGS);

  logic [SEG_W-1:0] size_q, size_d, cap_eff;
  resize_act_e      act;

  always_comb begin
    if (cap_i < MinV)      cap_eff = MinV;
    else if (cap_i > MaxV) cap_eff = MaxV;
    else                   cap_eff = cap_i;
  end

  // clamp first, then grow over shrink
  always_comb begin
    act = ACT_HOLD;
    if (size_q > cap_eff)
      act = ACT_CLAMP;
    else if ((loss_cnt_i > thr_hi_i) && (size_q < cap_eff))
      act = ACT_GROW;
    else if ((loss_cnt_i < thr_lo_i) && (size_q > MinV))
      act = ACT_SHRINK;
  end

  always_comb begin
    unique case (act)
      ACT_CLAMP:  size_d = cap_eff;
      ACT_GROW:   size_d = size_q + 1'b1;
      ACT_SHRINK: size_d = size_q - 1'b1;
      default:    size_d = size_q;
    endcase
  end

  assign grow_o = boundary_i && (act == ACT_GROW);
  assign size_o = size_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         size_q <= MaxV;
    else if (boundary_i) size_q <= size_d;
  end

  a_r5_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_q >= MinV);

  a_r6_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i |=> (size_q <= $past(cap_eff)));

  a_r1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> $stable(size_q));

  // R3: never grows by more than one segment
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i |=> ({1'b0, size_q} <= {1'b0, $past(size_q)} + 1'b1));

endmodule

// File: rtl/winrs_grow_stall.sv
module winrs_grow_stall #(
  parameter int GROW_DELAY = 5,
  localparam int SW = (GROW_DELAY < 1) ? 1 : $clog2(GROW_DELAY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grow_i,
  output logic stall_o
);

  if (GROW_DELAY == 0) begin : g_no_delay
    assign stall_o = 1'b0;
  end else begin : g_delay
    logic [SW-1:0] left_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             left_q <= '0;
      else if (grow_i)         left_q <= SW'(GROW_DELAY);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign stall_o = (left_q != '0);

    a_r7_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      left_q <= SW'(GROW_DELAY));

    a_r7_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grow_i |=> stall_o);
  end

endmodule

// File: rtl/winrs_window_resizer.sv
module winrs_window_resizer #(
  parameter int INTERVAL_CYCLES = 256,
  parameter int NUM_SEGS        = 16,
  parameter int MIN_SEGS        = 2,
  parameter int GROW_DELAY      = 5,
  localparam int SEG_W          = $clog2(NUM_SEGS + 1),
  localparam int CNT_W          = $clog2(INTERVAL_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hazard_i,
  input  logic [SEG_W-1:0] cap_i,
  input  logic [CNT_W-1:0] thr_hi_i,
  input  logic [CNT_W-1:0] thr_lo_i,
  output logic [SEG_W-1:0] active_segs_o,
  output logic             stall_o
);

  logic             boundary;
  logic             grow;
  logic [CNT_W-1:0] loss_cnt;

  winrs_interval_timer #(.INTERVAL_CYCLES(INTERVAL_CYCLES)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_o (boundary)
  );

  winrs_event_counter #(.CW(CNT_W)) u_events (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hazard_i   (hazard_i),
    .boundary_i (boundary),
    .loss_cnt_o (loss_cnt)
  );

  winrs_size_ctrl #(
    .NUM_SEGS (NUM_SEGS),
    .MIN_SEGS (MIN_SEGS),
    .CW       (CNT_W)
  ) u_size (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (boundary),
    .loss_cnt_i (loss_cnt),
    .thr_hi_i   (thr_hi_i),
    .thr_lo_i   (thr_lo_i),
    .cap_i      (cap_i),
    .size_o     (active_segs_o),
    .grow_o     (grow)
  );

  winrs_grow_stall #(.GROW_DELAY(GROW_DELAY)) u_stall (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .grow_i  (grow),
    .stall_o (stall_o)
  );

  // R7: a stall only ever begins together with a larger window
  a_r7_only_on_grow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> (active_segs_o > $past(active_segs_o)));

endmodule

// File: tb/sim_winrs_window_resizer.sv
module sim_winrs_window_resizer;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hazard = 1'b0;
  logic [4:0] cap = 5'd16;
  logic [8:0] thr_hi = 9'd100;
  logic [8:0] thr_lo = 9'd20;
  logic [4:0] segs;
  logic       stall;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  winrs_window_resizer u0 (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .hazard_i      (hazard),
    .cap_i         (cap),
    .thr_hi_i      (thr_hi),
    .thr_lo_i      (thr_lo),
    .active_segs_o (segs),
    .stall_o       (stall)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d, want %0d", req, act, exp);
    end
  endtask

  // One 256-cycle interval, started at a falling edge aligned to the timer.
  // st counts stall samples; chg counts size changes before the boundary.
  task automatic run_iv(input int n_ev, output int st, output int chg);
    int a0;
    st  = 0;
    chg = 0;
    a0  = int'(segs);
    for (int i = 0; i < 256; i++) begin
      if (stall) st++;
      if (int'(segs) != a0) chg++;
      hazard = (i < n_ev);
      @(negedge clk);
    end
    hazard = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 reset size", int'(segs), 16);
    chk("R8 reset stall", int'(stall), 0);
  endtask

  task automatic t_hold_and_shrink();
    int st, chg;
    run_iv(50, st, chg);
    chk("R1 stable inside interval", chg, 0);
    chk("R4 between thresholds holds", int'(segs), 16);
    run_iv(5, st, chg);
    chk("R4 shrink by one", int'(segs), 15);
    run_iv(5, st, chg);
    chk("R4 shrink again", int'(segs), 14);
    chk("R7 no stall on shrink", int'(stall), 0);
  endtask

  task automatic t_grow_stall();
    int st, chg;
    run_iv(200, st, chg);
    chk("R3 grow by one", int'(segs), 15);
    chk("R7 stall with grow", int'(stall), 1);
    run_iv(50, st, chg);
    chk("R7 stall length", st, 5);
    chk("R4 hold after grow", int'(segs), 15);
  endtask

  task automatic t_no_carry();
    int st, chg;
    run_iv(255, st, chg);
    chk("R3 grow to 16", int'(segs), 16);
    run_iv(5, st, chg);
    chk("R2 no carryover, shrinks", int'(segs), 15);
    chk("R7 second grow stall", st, 5);
  endtask

  task automatic t_exact_thresholds();
    int st, chg;
    run_iv(100, st, chg);
    chk("R4 count equal high holds", int'(segs), 15);
    run_iv(20, st, chg);
    chk("R4 count equal low holds", int'(segs), 15);
  endtask

  task automatic t_cap();
    int st, chg;
    cap = 5'd15;
    run_iv(200, st, chg);
    chk("R6 no grow past cap", int'(segs), 15);
    chk("R7 no stall at cap", int'(stall), 0);
    cap = 5'd10;
    run_iv(50, st, chg);
    chk("R6 clamp to cap", int'(segs), 10);
    chk("R7 no stall on clamp", int'(stall), 0);
  endtask

  task automatic t_floor();
    int st, chg;
    cap = 5'd16;
    for (int k = 0; k < 8; k++) run_iv(0, st, chg);
    chk("R5 drains to floor", int'(segs), 2);
    run_iv(0, st, chg);
    chk("R5 floor holds", int'(segs), 2);
  endtask

  task automatic t_cap_range();
    int st, chg;
    cap = 5'd0;
    run_iv(200, st, chg);
    chk("R6 cap below floor treated as 2", int'(segs), 2);
    cap = 5'd31;
    run_iv(256, st, chg);
    chk("R6 cap above max, R3 grows", int'(segs), 3);
  endtask

  task automatic t_priority();
    int st, chg;
    thr_lo = 9'd200;
    thr_hi = 9'd100;
    run_iv(150, st, chg);
    chk("R9 grow wins over shrink", int'(segs), 4);
    thr_lo = 9'd20;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_hold_and_shrink();
    t_grow_stall();
    t_no_carry();
    t_exact_thresholds();
    t_cap();
    t_floor();
    t_cap_range();
    t_priority();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, want completion");
    finish_run();
  end

endmodule